// File: doc/BRIEF.md
# I/O Port Bus Access Sequencer

This block turns one processor request to read or write an I/O port into one or two cycles on a 32-bit external bus with four byte lanes. The I/O space is separate from memory. It holds 65536 byte-wide ports, selected by a 16-bit port number. A transfer covers one, two or four consecutive ports, starting at the given port number. The port number comes either from an 8-bit immediate, which is zero-extended, or from a 16-bit register.

The block drives a doubleword address, which is the port number without its two low bits. It also drives per-lane byte enables, the write data with each byte moved to its own lane, and a strobe. It holds all of these until the device raises ready. When the bytes of a request fall into two doublewords, the request becomes two bus cycles: the lower doubleword first, then the next doubleword address. On a read, the lanes returned by both cycles are gathered and right-justified into one result. A one-cycle done pulse marks the end of the request.

Top module: `io_port_seq`

## Requirements
- R1: With `req_src_wide`=1 the port number is `req_reg[15:0]`. With `req_src_wide`=0 it is `{8'h00, req_imm}`, and `req_reg` has no effect.
- R2: Size encoding on `req_size`: 00 is 8 bits, 01 is 16 bits, 10 and 11 are 32 bits. The first cycle drives `bus_addr` = port[15:2] and sets `bus_be[j]` for every byte of the request whose port number has low two bits j and lies in that doubleword. `bus_be` is never zero while the strobe is high.
- R3: A request whose bytes all lie in one doubleword takes exactly one bus cycle. This covers every 8-bit request, a 16-bit request at offset 0, 1 or 2, and a 32-bit request at a port number that is a multiple of 4.
- R4: A request whose bytes cross a doubleword boundary takes exactly two bus cycles. The second cycle comes after the first and has `bus_addr` one higher, modulo 2^14, with the enables of the remaining bytes.
- R5: On a write, byte i of `req_wdata` (bits 8i+7:8i) appears on the lane given by the low two bits of port+i, in the cycle that addresses that port. `bus_write` is 1 for writes and 0 for reads.
- R6: On a read, byte i of `rd_data` is the byte on the lane of port+i in the cycle that addressed it. Bytes of `rd_data` above the transfer size are zero.
- R7: While `bus_strobe` is high and `bus_ready` is low, `bus_addr`, `bus_be`, `bus_wdata`, `bus_write` and the strobe itself stay unchanged in the next cycle.
- R8: `done` is high for exactly one clock, in the cycle after the clock edge at which the final cycle sees `bus_ready`. In that cycle `busy` and `bus_strobe` are low, and after a read `rd_data` holds the result.
- R9: A request is accepted only when `req_valid` is high while `busy` is low. `busy` is high from the cycle after acceptance until done. `req_valid` during `busy` has no effect on the bus.
- R10: While `rst_n` is low, `bus_strobe`, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write to port, 0 = read |
| req_size | input | 2 | Transfer size code (R2) |
| req_src_wide | input | 1 | 1 = port from register, 0 = from immediate |
| req_imm | input | 8 | Immediate port number |
| req_reg | input | 16 | Register port number |
| req_wdata | input | 32 | Write data, right-justified |
| bus_addr | output | 14 | Doubleword address |
| bus_be | output | 4 | Byte lane enables |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_write | output | 1 | Cycle direction |
| bus_strobe | output | 1 | Cycle in progress |
| bus_ready | input | 1 | Device completes the cycle |
| bus_rdata | input | 32 | Device read lanes |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Right-justified read result |

## Verification
The bench targets boundary offsets. A 16-bit access at offset 3 must split, while the same access at offset 2 must not; a wrong span test would either split a legal access or drop its top byte. A 32-bit access at offsets 1 to 3 checks the ordering of the two cycles and the lane steering, and a wrong shift shows up as bytes landing in the wrong lane or returned in the wrong order. Port 0xFFFF exercises the address wrap, and an immediate source paired with a random register value catches a design that does not zero-extend or picks the wrong source. Random ready delays with stray requests during a cycle catch a design that lets the bus drift or accepts work while busy.

// File: rtl/io_seq_pkg.sv
package io_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } seq_st_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;

  // true when byte position 'lane' of a request lies inside the transfer size
  function automatic logic lane_used(input logic [1:0] size, input int lane);
    case (size)
      SZ_BYTE: return (lane < 1);
      SZ_WORD: return (lane < 2);
      default: return (lane < 4);
    endcase
  endfunction

endpackage

// File: rtl/io_seq_plan.sv
module io_seq_plan
  import io_seq_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int LANES  = 4
) (
  input  logic [PORT_W-1:0]                port,
  input  logic [1:0]                       size,
  output logic [PORT_W-$clog2(LANES)-1:0]  addr_lo,
  output logic [PORT_W-$clog2(LANES)-1:0]  addr_hi,
  output logic [LANES-1:0]                 be_lo,
  output logic [LANES-1:0]                 be_hi,
  output logic                             split,
  output logic [$clog2(LANES)-1:0]         off
);
  localparam int OFF_W  = $clog2(LANES);
  localparam int ADDR_W = PORT_W - OFF_W;

  logic [LANES-1:0]   len_mask;
  logic [2*LANES-1:0] span;

  for (genvar i = 0; i < LANES; i++) begin : g_len
    assign len_mask[i] = lane_used(size, i);
  end

  assign off     = port[OFF_W-1:0];
  assign span    = {{LANES{1'b0}}, len_mask} << off;
  assign be_lo   = span[LANES-1:0];
  assign be_hi   = span[2*LANES-1:LANES];
  assign split   = |be_hi;
  assign addr_lo = port[PORT_W-1:OFF_W];
  assign addr_hi = addr_lo + ADDR_W'(1);

  // R3: an aligned full-width access never needs a second cycle
  always_comb begin
    if (size != SZ_BYTE && size != SZ_WORD && off == '0) begin
      p_aligned_single_r3: assert (!split);
    end
  end

endmodule

// File: rtl/io_seq_wsteer.sv
module io_seq_wsteer
  import io_seq_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0]       wdata,
  input  logic [1:0]               size,
  input  logic [$clog2(LANES)-1:0] off,
  output logic [8*LANES-1:0]       lane_lo,
  output logic [8*LANES-1:0]       lane_hi
);
  localparam int DATA_W = 8 * LANES;
  localparam int OFF_W  = $clog2(LANES);

  logic [DATA_W-1:0]   trimmed;
  logic [2*DATA_W-1:0] moved;
  logic [OFF_W+2:0]    shamt;

  for (genvar i = 0; i < LANES; i++) begin : g_trim
    assign trimmed[8*i +: 8] = lane_used(size, i) ? wdata[8*i +: 8] : 8'h00;
  end

  assign shamt   = {off, 3'b000};
  assign moved   = {{DATA_W{1'b0}}, trimmed} << shamt;
  assign lane_lo = moved[DATA_W-1:0];
  assign lane_hi = moved[2*DATA_W-1:DATA_W];

endmodule

// File: rtl/io_seq_rpack.sv
module io_seq_rpack
  import io_seq_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [16*LANES-1:0]      gathered,
  input  logic [1:0]               size,
  input  logic [$clog2(LANES)-1:0] off,
  output logic [8*LANES-1:0]       result
);
  localparam int DATA_W = 8 * LANES;
  localparam int OFF_W  = $clog2(LANES);

  logic [2*DATA_W-1:0] aligned;
  logic [OFF_W+2:0]    shamt;

  assign shamt   = {off, 3'b000};
  assign aligned = gathered >> shamt;

  for (genvar i = 0; i < LANES; i++) begin : g_pack
    assign result[8*i +: 8] = lane_used(size, i) ? aligned[8*i +: 8] : 8'h00;
  end

endmodule

// File: rtl/io_port_seq.sv
module io_port_seq
  import io_seq_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int IMM_W  = 8,
  parameter int LANES  = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  input  logic                             req_write,
  input  logic [1:0]                       req_size,
  input  logic                             req_src_wide,
  input  logic [IMM_W-1:0]                 req_imm,
  input  logic [PORT_W-1:0]                req_reg,
  input  logic [8*LANES-1:0]               req_wdata,
  output logic [PORT_W-$clog2(LANES)-1:0]  bus_addr,
  output logic [LANES-1:0]                 bus_be,
  output logic [8*LANES-1:0]               bus_wdata,
  output logic                             bus_write,
  output logic                             bus_strobe,
  input  logic                             bus_ready,
  input  logic [8*LANES-1:0]               bus_rdata,
  output logic                             busy,
  output logic                             done,
  output logic [8*LANES-1:0]               rd_data
);
  localparam int OFF_W  = $clog2(LANES);
  localparam int ADDR_W = PORT_W - OFF_W;
  localparam int DATA_W = 8 * LANES;

  // ---------------- request decode ----------------
  logic [PORT_W-1:0] port_sel;
  assign port_sel = req_src_wide ? req_reg : {{(PORT_W-IMM_W){1'b0}}, req_imm};

  logic [ADDR_W-1:0] pl_addr_lo, pl_addr_hi;
  logic [LANES-1:0]  pl_be_lo, pl_be_hi;
  logic              pl_split;
  logic [OFF_W-1:0]  pl_off;
  logic [DATA_W-1:0] ws_lo, ws_hi;

  io_seq_plan #(.PORT_W(PORT_W), .LANES(LANES)) u_plan (
    .port    (port_sel),
    .size    (req_size),
    .addr_lo (pl_addr_lo),
    .addr_hi (pl_addr_hi),
    .be_lo   (pl_be_lo),
    .be_hi   (pl_be_hi),
    .split   (pl_split),
    .off     (pl_off)
  );

  io_seq_wsteer #(.LANES(LANES)) u_wsteer (
    .wdata   (req_wdata),
    .size    (req_size),
    .off     (pl_off),
    .lane_lo (ws_lo),
    .lane_hi (ws_hi)
  );

  // ---------------- state ----------------
  seq_st_e           st_q, st_d;
  logic [ADDR_W-1:0] addr_lo_q, addr_hi_q;
  logic [LANES-1:0]  be_lo_q, be_hi_q;
  logic [DATA_W-1:0] wd_lo_q, wd_hi_q;
  logic              split_q, wr_q;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        size_q;
  logic [DATA_W-1:0] rlo_q, rhi_q, rlo_d, rhi_d;
  logic [DATA_W-1:0] rd_q, packed_rd;
  logic              done_q;
  logic              accept, cap_lo, cap_hi, finish;

  // next-state logic
  always_comb begin
    st_d   = st_q;
    accept = 1'b0;
    cap_lo = 1'b0;
    cap_hi = 1'b0;
    finish = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          st_d   = ST_LO;
        end
      end
      ST_LO: begin
        if (bus_ready) begin
          cap_lo = 1'b1;
          if (split_q) begin
            st_d = ST_HI;
          end else begin
            st_d   = ST_IDLE;
            finish = 1'b1;
          end
        end
      end
      ST_HI: begin
        if (bus_ready) begin
          cap_hi = 1'b1;
          st_d   = ST_IDLE;
          finish = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign rlo_d = cap_lo ? bus_rdata : rlo_q;
  assign rhi_d = cap_hi ? bus_rdata : rhi_q;

  io_seq_rpack #(.LANES(LANES)) u_rpack (
    .gathered (({rhi_d, rlo_d})),
    .size     (size_q),
    .off      (off_q),
    .result   (packed_rd)
  );

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
    end
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lo_q <= '0;
      addr_hi_q <= '0;
      be_lo_q   <= '0;
      be_hi_q   <= '0;
      wd_lo_q   <= '0;
      wd_hi_q   <= '0;
      split_q   <= 1'b0;
      wr_q      <= 1'b0;
      off_q     <= '0;
      size_q    <= SZ_BYTE;
    end else if (accept) begin
      addr_lo_q <= pl_addr_lo;
      addr_hi_q <= pl_addr_hi;
      be_lo_q   <= pl_be_lo;
      be_hi_q   <= pl_be_hi;
      wd_lo_q   <= ws_lo;
      wd_hi_q   <= ws_hi;
      split_q   <= pl_split;
      wr_q      <= req_write;
      off_q     <= pl_off;
      size_q    <= req_size;
    end
  end

  // read lane collection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rlo_q <= '0;
      rhi_q <= '0;
    end else if (accept) begin
      rlo_q <= '0;
      rhi_q <= '0;
    end else if (cap_lo || cap_hi) begin
      rlo_q <= rlo_d;
      rhi_q <= rhi_d;
    end
  end

  // read result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (finish && !wr_q) begin
      rd_q <= packed_rd;
    end
  end

  // ---------------- outputs ----------------
  assign bus_strobe = (st_q != ST_IDLE);
  assign bus_addr   = (st_q == ST_HI) ? addr_hi_q : addr_lo_q;
  assign bus_be     = (st_q == ST_HI) ? be_hi_q   : (st_q == ST_LO) ? be_lo_q : '0;
  assign bus_wdata  = (st_q == ST_HI) ? wd_hi_q   : wd_lo_q;
  assign bus_write  = wr_q;
  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign rd_data    = rd_q;

  // ---------------- assertions ----------------
  p_hold_until_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && !bus_ready) |=> (bus_strobe && $stable(bus_addr) && $stable(bus_be)
                                    && $stable(bus_wdata) && $stable(bus_write)));

  p_second_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HI && $past(st_q) == ST_LO) |-> (bus_addr == $past(bus_addr) + ADDR_W'(1)));

  p_be_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |-> (bus_be != '0));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !bus_strobe));

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

endmodule

// File: tb/tb_io_port_seq.sv
`timescale 1ns/1ps
module tb_io_port_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_src_wide;
  logic [1:0]  req_size;
  logic [7:0]  req_imm;
  logic [15:0] req_reg;
  logic [31:0] req_wdata;
  logic [13:0] bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata, rd_data;
  logic        bus_write, bus_strobe, bus_ready, busy, done;

  always #5 clk = ~clk;

  io_port_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_src_wide(req_src_wide), .req_imm(req_imm),
    .req_reg(req_reg), .req_wdata(req_wdata), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_write(bus_write), .bus_strobe(bus_strobe),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .busy(busy), .done(done),
    .rd_data(rd_data)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dev_byte(input logic [15:0] p);
    return (p[7:0] * 8'd37) ^ p[15:8] ^ 8'hC3;
  endfunction

  // check bus fields of the current cycle against expectations
  task automatic chk_cycle(input int c, input bit wr, input logic [13:0] ea,
                           input logic [3:0] eb, input logic [31:0] ew, input string tag);
    chk(bus_strobe === 1'b1, {"R7 strobe ", tag}, 64'(bus_strobe), 64'd1);
    chk(bus_addr === ea, (c == 0) ? {"R2 addr ", tag} : {"R4 addr ", tag}, 64'(bus_addr), 64'(ea));
    chk(bus_be === eb, (c == 0) ? {"R2 be ", tag} : {"R4 be ", tag}, 64'(bus_be), 64'(eb));
    chk(bus_write === wr, {"R5 dir ", tag}, 64'(bus_write), 64'(wr));
    if (wr) begin
      for (int j = 0; j < 4; j++) begin
        if (eb[j]) chk(bus_wdata[8*j +: 8] === ew[8*j +: 8], {"R5 lane ", tag},
                       64'(bus_wdata[8*j +: 8]), 64'(ew[8*j +: 8]));
      end
    end
  endtask

  // one full request; entered and left at a falling edge
  task automatic run(input bit wr, input logic [1:0] sz, input bit wide, input logic [7:0] imm,
                     input logic [15:0] rg, input logic [31:0] wd, input int maxdly);
    logic [15:0] p;
    int          nb, ncyc;
    logic [13:0] ea [2];
    logic [3:0]  eb [2];
    logic [31:0] ew [2];
    logic [31:0] er;
    p  = wide ? rg : {8'h00, imm};                     // R1
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    ea[0] = p[15:2];
    ea[1] = p[15:2] + 14'd1;
    eb[0] = '0; eb[1] = '0; ew[0] = '0; ew[1] = '0; er = '0;
    for (int i = 0; i < nb; i++) begin
      logic [15:0] q;
      int          c;
      q = p + 16'(i);
      c = ((int'(p[1:0]) + i) >= 4) ? 1 : 0;
      eb[c][q[1:0]] = 1'b1;
      ew[c][8*q[1:0] +: 8] = wd[8*i +: 8];
      er[8*i +: 8] = dev_byte(q);
    end
    ncyc = (eb[1] != '0) ? 2 : 1;

    req_valid = 1'b1; req_write = wr; req_size = sz; req_src_wide = wide;
    req_imm = imm; req_reg = rg; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R9 busy after accept", 64'(busy), 64'd1);

    for (int c = 0; c < ncyc; c++) begin
      int d;
      chk_cycle(c, wr, ea[c], eb[c], ew[c], "start");
      d = $urandom_range(0, maxdly);
      for (int k = 0; k < d; k++) begin
        // stray request while busy: must not disturb the bus (R9)
        req_valid = 1'b1; req_write = ~wr; req_size = $urandom_range(0, 3);
        req_src_wide = 1'b1; req_reg = 16'($urandom); req_wdata = $urandom;
        @(negedge clk);
        req_valid = 1'b0;
        chk_cycle(c, wr, ea[c], eb[c], ew[c], "held R9");
      end
      bus_ready = 1'b1;
      bus_rdata = {dev_byte({ea[c], 2'd3}), dev_byte({ea[c], 2'd2}),
                   dev_byte({ea[c], 2'd1}), dev_byte({ea[c], 2'd0})};
      @(negedge clk);
      bus_ready = 1'b0;
      bus_rdata = 32'hDEAD_BEEF;
    end

    chk(bus_strobe === 1'b0, (ncyc == 1) ? "R3 no extra cycle" : "R4 no third cycle",
        64'(bus_strobe), 64'd0);
    chk(done === 1'b1, "R8 done after final", 64'(done), 64'd1);
    chk(busy === 1'b0, "R8 busy low at done", 64'(busy), 64'd0);
    if (!wr) chk(rd_data === er, "R6 read result", 64'(rd_data), 64'(er));
    @(negedge clk);
    chk(done === 1'b0, "R8 done one clock", 64'(done), 64'd0);
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1B5C_0D17));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0; req_src_wide = 1'b0;
    req_imm = '0; req_reg = '0; req_wdata = '0; bus_ready = 1'b0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    chk(bus_strobe === 1'b0, "R10 strobe in reset", 64'(bus_strobe), 64'd0);
    chk(busy === 1'b0, "R10 busy in reset", 64'(busy), 64'd0);
    chk(done === 1'b0, "R10 done in reset", 64'(done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run(1'b0, 2'd0, 1'b0, 8'hFF, 16'hABCD, 32'h0, 2);          // R1 imm zero-extended
    run(1'b1, 2'd0, 1'b0, 8'h13, 16'hFFFF, 32'h0000_00A5, 1);  // R1 reg ignored
    run(1'b1, 2'd2, 1'b1, 8'h00, 16'h1234, 32'h1122_3344, 0);  // R3 aligned dword
    run(1'b0, 2'd1, 1'b1, 8'h00, 16'h0202, 32'h0, 1);          // R3 word offset 2
    run(1'b0, 2'd1, 1'b1, 8'h00, 16'h0203, 32'h0, 1);          // R4 word offset 3
    run(1'b1, 2'd1, 1'b1, 8'h00, 16'h0407, 32'h0000_BEEF, 2);  // R4/R5 word split write
    for (int o = 1; o < 4; o++) begin
      run(1'b0, 2'd2, 1'b1, 8'h00, 16'h5550 + 16'(o), 32'h0, 2);       // R4/R6
      run(1'b1, 2'd3, 1'b1, 8'h00, 16'h6660 + 16'(o), 32'hCAFE_F00D, 2); // R4/R5
    end
    run(1'b0, 2'd1, 1'b1, 8'h00, 16'hFFFF, 32'h0, 1);          // R4 wrap
    run(1'b1, 2'd2, 1'b1, 8'h00, 16'hFFFE, 32'h8765_4321, 1);  // R4 wrap write
    run(1'b0, 2'd0, 1'b1, 8'h00, 16'h8001, 32'h0, 0);          // R3 odd byte

    // constrained random
    for (int n = 0; n < 400; n++) begin
      run(1'($urandom), 2'($urandom_range(0, 3)), 1'($urandom), 8'($urandom),
          16'($urandom), $urandom, 3);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule